// File: doc/BRIEF.md
# Mandelbrot Escape-Time Iteration Engine

This block takes a single point c = a + ib of the complex plane and reports how many iterations of z := z² + c it takes before the orbit leaves the radius-2 disc. The complex recurrence is evaluated with real arithmetic only. On each step the real part becomes x² − y² + a and the imaginary part becomes 2·x·y + b. Escape is tested on the squared magnitude, so the datapath needs no square root and no complex multiplier. The orbit starts at z = 0.

A caller places the point and an iteration limit on the inputs and pulses `start` while the engine is idle. The engine then works through one iteration per clock. It finishes when the point escapes or when the limit is reached. At that moment it pulses `done` and holds the iteration count and the escaped flag until the next run completes. Points that stay bounded up to the limit are reported as not escaped, which is how members of the set are identified. Mapping pixels to coordinates, colouring and video output are left to the surrounding logic.

Top module: `mandel_escape_engine`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy`, `done`, `iter_count` and `escaped` are all 0.
- R2: `start` is taken only when `busy` is low. The inputs `c_re`, `c_im` and `max_iter` are captured on that edge and `busy` reads 1 in the next cycle. A `start` raised while `busy` is high has no effect on the run in progress or on its result.
- R3: Coordinates are signed Q4.12 (16 bits, 1.0 = 4096). Each product is formed at full width, arithmetically shifted right by 12 (rounding toward minus infinity) and saturated to the range −32768..32767. The new x is sat(x² − y² + a) and the new y is sat(2·xy + b), each saturated to the same range. The orbit starts from x = y = 0.
- R4: Escape is detected when x² + y² > 16384 (4.0), using the truncated and saturated squares of the current iteration. A sum of exactly 16384 does not escape.
- R5: On escape, `escaped` = 1 and `iter_count` equals the number of updates applied before the escaping value was examined. For example, a = 3.0, b = 0 gives 1.
- R6: If no escape occurs, the run ends after `max_iter` updates with `escaped` = 0 and `iter_count` = `max_iter`. `max_iter` = 0 ends with a count of 0. When escape and the limit coincide, escape is reported.
- R7: `done` is high for exactly one cycle per run, and `busy` is low in that cycle.
- R8: `iter_count` and `escaped` change only in the cycle in which `done` is high.
- R9: `done` is seen `iter_count` + 1 clock edges after the edge that accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a run (honoured only when idle) |
| c_re | input | 16 | Real part a of c, signed Q4.12 |
| c_im | input | 16 | Imaginary part b of c, signed Q4.12 |
| max_iter | input | 8 | Iteration limit |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| iter_count | output | 8 | Iterations taken |
| escaped | output | 1 | Point left the radius-2 disc |

## Verification
The assertions assume that `start` is meaningful only as a level sampled while idle. They also assume that the limit of a run is the `max_iter` value present on the accepting edge, so changes to `max_iter` or the coordinates during a run must be harmless. The stimulus reflects this. It changes the coordinates and pulses `start` in the middle of a run and expects the original result back. Each point is presented only when the engine is idle, and the bench waits for `done` before it presents the next one.

// File: rtl/mandel_pkg.sv
package mandel_pkg;
  parameter int unsigned COORD_W = 16;
  parameter int unsigned FRAC_W  = 12;
  parameter int unsigned ITER_W  = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } eng_state_e;
endpackage

// File: rtl/mandel_sat.sv
// Clamp a wide signed value into a narrower signed range.
module mandel_sat #(
  parameter int IW = 32,
  parameter int OW = 16
) (
  input  logic signed [IW-1:0] din,
  output logic signed [OW-1:0] dout
);
  localparam logic signed [IW-1:0] HI = IW'((64'sd1 <<< (OW-1)) - 64'sd1);
  localparam logic signed [IW-1:0] LO = ~HI;

  always_comb begin
    if (din > HI)      dout = HI[OW-1:0];
    else if (din < LO) dout = LO[OW-1:0];
    else               dout = din[OW-1:0];
  end
endmodule

// File: rtl/mandel_fxmul.sv
// Full-width signed product, rescaled by FRAC bits and clamped.
module mandel_fxmul #(
  parameter int W    = 16,
  parameter int FRAC = 12
) (
  input  logic signed [W-1:0] op_l,
  input  logic signed [W-1:0] op_r,
  output logic signed [W-1:0] prod
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] full;
  logic signed [PW-1:0] scaled;

  assign full   = PW'(op_l) * PW'(op_r);
  assign scaled = full >>> FRAC;

  mandel_sat #(.IW(PW), .OW(W)) u_sat (
    .din  (scaled),
    .dout (prod)
  );
endmodule

// File: rtl/mandel_step.sv
// One iteration of the real-valued recurrence plus the escape test.
module mandel_step #(
  parameter int W    = 16,
  parameter int FRAC = 12
) (
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] y,
  input  logic signed [W-1:0] ca,
  input  logic signed [W-1:0] cb,
  output logic signed [W-1:0] nx,
  output logic signed [W-1:0] ny,
  output logic                escape
);
  localparam int NMUL = 3;
  localparam int SW   = W + 2;
  localparam logic signed [SW-1:0] ESC_LIM = SW'(64'sd4 <<< FRAC);

  // product slots: 0 = x*x, 1 = y*y, 2 = x*y
  logic signed [W-1:0] lhs [NMUL];
  logic signed [W-1:0] rhs [NMUL];
  logic signed [W-1:0] sq  [NMUL];

  always_comb begin
    lhs[0] = x;  rhs[0] = x;
    lhs[1] = y;  rhs[1] = y;
    lhs[2] = x;  rhs[2] = y;
  end

  for (genvar g = 0; g < NMUL; g++) begin : g_mul
    mandel_fxmul #(.W(W), .FRAC(FRAC)) u_mul (
      .op_l (lhs[g]),
      .op_r (rhs[g]),
      .prod (sq[g])
    );
  end

  logic signed [SW-1:0] mag;
  logic signed [SW-1:0] sums [2];
  logic signed [W-1:0]  outs [2];

  // magnitude reuses the two squares of this iteration
  assign mag    = SW'(sq[0]) + SW'(sq[1]);
  assign escape = mag > ESC_LIM;

  always_comb begin
    sums[0] = SW'(sq[0]) - SW'(sq[1]) + SW'(ca);
    sums[1] = (SW'(sq[2]) <<< 1) + SW'(cb);
  end

  for (genvar k = 0; k < 2; k++) begin : g_sat
    mandel_sat #(.IW(SW), .OW(W)) u_sat (
      .din  (sums[k]),
      .dout (outs[k])
    );
  end

  assign nx = outs[0];
  assign ny = outs[1];
endmodule

// File: rtl/mandel_ctrl.sv
// Run control: accept, iteration counting, termination and result hold.
module mandel_ctrl
  import mandel_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] max_iter,
  input  logic          escape,
  output logic          busy,
  output logic          done,
  output logic          load,
  output logic          step_en,
  output logic [CW-1:0] count,
  output logic          escaped
);
  eng_state_e    st_q, st_d;
  logic [CW-1:0] lim_q;
  logic [CW-1:0] iter_q, iter_d;
  logic          accept, at_limit, running, finish;
  logic          done_q, esc_q;
  logic [CW-1:0] cnt_q;

  assign running  = (st_q == ST_RUN);
  assign accept   = (st_q == ST_IDLE) && start;
  assign at_limit = (iter_q == lim_q);
  assign finish   = running && (escape || at_limit);
  assign step_en  = running && !escape && !at_limit;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_RUN;
      ST_RUN:  if (finish) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    iter_d = iter_q;
    if (accept)       iter_d = '0;
    else if (step_en) iter_d = iter_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 iter_q <= '0;
    else if (accept || step_en) iter_q <= iter_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= '0;
    else if (accept) lim_q <= max_iter;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      esc_q <= 1'b0;
    end else if (finish) begin
      cnt_q <= iter_q;
      esc_q <= escape;
    end
  end

  assign busy    = running;
  assign done    = done_q;
  assign load    = accept;
  assign count   = cnt_q;
  assign escaped = esc_q;
endmodule

// File: rtl/mandel_escape_engine.sv
module mandel_escape_engine
  import mandel_pkg::*;
#(
  parameter int W    = COORD_W,
  parameter int FRAC = FRAC_W,
  parameter int CW   = ITER_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] c_re,
  input  logic signed [W-1:0] c_im,
  input  logic [CW-1:0]       max_iter,
  output logic                busy,
  output logic                done,
  output logic [CW-1:0]       iter_count,
  output logic                escaped
);
  logic signed [W-1:0] x_q, y_q, a_q, b_q;
  logic signed [W-1:0] nx, ny;
  logic                escape, load, step_en;

  mandel_step #(.W(W), .FRAC(FRAC)) u_step (
    .x      (x_q),
    .y      (y_q),
    .ca     (a_q),
    .cb     (b_q),
    .nx     (nx),
    .ny     (ny),
    .escape (escape)
  );

  mandel_ctrl #(.CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .max_iter (max_iter),
    .escape   (escape),
    .busy     (busy),
    .done     (done),
    .load     (load),
    .step_en  (step_en),
    .count    (iter_count),
    .escaped  (escaped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= c_re;
      b_q <= c_im;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (load) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step_en) begin
      x_q <= nx;
      y_q <= ny;
    end
  end
endmodule

// File: rtl/mandel_escape_engine_chk.sv
module mandel_escape_engine_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] max_iter,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] iter_count,
  input logic          escaped
);
  logic [CW-1:0] lim_seen;
  logic [CW:0]   run_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lim_seen <= '0;
    else if (start && !busy) lim_seen <= max_iter;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_cyc <= '0;
    else if (start && !busy) run_cyc <= '0;
    else if (busy)           run_cyc <= run_cyc + 1'b1;
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R7
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(iter_count) && $stable(escaped))); // R8
  AST_LIMIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (done && !escaped) |-> (iter_count == lim_seen)); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) done |-> (iter_count <= lim_seen)); // R5
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (run_cyc == ((CW+1)'(iter_count) + 1'b1))); // R9
endmodule

bind mandel_escape_engine mandel_escape_engine_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .max_iter   (max_iter),
  .busy       (busy),
  .done       (done),
  .iter_count (iter_count),
  .escaped    (escaped)
);

// File: tb/tb_mandel_escape_engine.sv
`timescale 1ns/1ps
module tb_mandel_escape_engine;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               start;
  logic signed [15:0] c_re, c_im;
  logic [7:0]         max_iter;
  logic               busy, done, escaped;
  logic [7:0]         iter_count;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  mandel_escape_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .c_re(c_re), .c_im(c_im),
    .max_iter(max_iter), .busy(busy), .done(done),
    .iter_count(iter_count), .escaped(escaped)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // arithmetic reference per R3..R6
  task automatic model(input int a, input int b, input int lim, output int cnt, output bit esc);
    longint x = 0, y = 0, xx, yy, xy;
    cnt = lim; esc = 1'b0;
    for (int n = 0; n <= lim; n++) begin
      xx = sat((x * x) >>> 12);
      yy = sat((y * y) >>> 12);
      xy = sat((x * y) >>> 12);
      if (xx + yy > 16384) begin cnt = n; esc = 1'b1; return; end
      if (n == lim) begin cnt = lim; esc = 1'b0; return; end
      x = sat(xx - yy + a);
      y = sat(2 * xy + b);
    end
  endtask

  // runs one point; optional mid-run start with other coordinates (R2)
  task automatic run_pt(input int a, input int b, input int lim, input int poke_at,
                        output int cnt, output bit esc, output int lat);
    int cyc;
    @(negedge clk);
    c_re = 16'(a); c_im = 16'(b); max_iter = 8'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    while (!done) begin
      if (cyc == poke_at) begin
        c_re = 16'sd12288; c_im = 16'sd0; max_iter = 8'd3; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (cyc > 700) begin
        check(1'b0, "watchdog run", cyc, 0);
        break;
      end
    end
    start = 1'b0;
    cnt = int'(iter_count);
    esc = escaped;
    lat = cyc - 1;
    check(busy == 1'b0, "R7 busy low with done", int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done single cycle", int'(done), 0);
    check(int'(iter_count) == cnt && escaped == esc, "R8 result held", int'(iter_count), cnt);
  endtask

  task automatic expect_pt(input int a, input int b, input int lim, input string tag);
    int cnt, ecnt, lat;
    bit esc, eesc;
    model(a, b, lim, ecnt, eesc);
    run_pt(a, b, lim, -1, cnt, esc, lat);
    check(cnt == ecnt, {tag, " count"}, cnt, ecnt);
    check(esc == eesc, {tag, " escaped"}, int'(esc), int'(eesc));
    check(lat == cnt + 1, "R9 latency", lat, cnt + 1);
  endtask

  initial begin
    #(5.0 * 190000);
    check(1'b0, "watchdog global", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt, lat;
    bit esc;
    rst_n = 1'b0; start = 1'b0; c_re = '0; c_im = '0; max_iter = '0;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && iter_count == 0 && escaped == 0, "R1 in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && iter_count == 0 && escaped == 0, "R1 after reset", int'(iter_count), 0);

    // R5: a=3.0 escapes after one update
    run_pt(12288, 0, 255, -1, cnt, esc, lat);
    check(cnt == 1 && esc == 1, "R5 a=3.0", cnt, 1);
    check(lat == 2, "R9 a=3.0 latency", lat, 2);

    // R6: origin never escapes
    run_pt(0, 0, 255, -1, cnt, esc, lat);
    check(cnt == 255 && esc == 0, "R6 limit 255", cnt, 255);
    run_pt(0, 0, 0, -1, cnt, esc, lat);
    check(cnt == 0 && esc == 0, "R6 limit 0", cnt, 0);
    check(lat == 1, "R9 limit 0 latency", lat, 1);

    // R6: escape coinciding with the limit reports escape
    run_pt(12288, 0, 1, -1, cnt, esc, lat);
    check(cnt == 1 && esc == 1, "R6 escape at limit", int'(esc), 1);

    // R4: a=-2 sits at |z|^2 = 4 forever, no escape
    run_pt(-8192, 0, 50, -1, cnt, esc, lat);
    check(cnt == 50 && esc == 0, "R4 equal to four", cnt, 50);
    // R4: a=2 reaches exactly 4, then saturates and escapes at update 2
    run_pt(8192, 0, 50, -1, cnt, esc, lat);
    check(cnt == 2 && esc == 1, "R4 a=2.0", cnt, 2);

    // R2: start while busy is ignored
    run_pt(0, 0, 40, 5, cnt, esc, lat);
    check(cnt == 40 && esc == 0, "R2 start ignored while busy", cnt, 40);

    // R3 saturation corners
    expect_pt(-32768, 32767, 20, "R3 corner");
    expect_pt(32767, -32768, 20, "R3 corner");
    expect_pt(-32768, -32768, 20, "R3 corner");

    // R3 grid sweep
    for (int ia = -10240; ia <= 4096; ia += 512)
      for (int ib = -5120; ib <= 5120; ib += 640)
        expect_pt(ia, ib, 24, "R3 sweep");

    // R6 limit sweep on a slowly escaping point
    for (int l = 0; l < 16; l++)
      expect_pt(1500, 2600, l, "R6 limit sweep");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule